// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synchronous single-port memory with a 36-bit word built from four 9-bit byte lanes. Each lane carries eight data bits and one parity bit, and the memory treats all nine bits as plain storage. Commands are taken on rising clock edges and may follow one another every cycle in any mix of reads and writes. No idle cycle is needed when the bus changes direction, because a write's data arrives on the input bus in the same slot where a read's data would leave on the output bus: two enabled edges after the command.

A command either loads a fresh address or continues a short burst from the last loaded address. The burst order is fixed by a parameter. A global active-low clock enable freezes the entire block, including commands already in flight. Output enable is asynchronous and only gates the output drivers. The split output bus comes with a drive-enable flag that stands in for a tristate pad.

Top module: `turnless_sram`

## Requirements
- R1: A read command is an enabled edge (cenN=0) with advN=0, the chip selected and weN=1. The addressed word is on dOut, with dOutValid=1, right after the second enabled edge that follows the command edge.
- R2: A write command registers its address on its own edge. The data on dIn and the lane strobes bwN are sampled at the second enabled edge after the command. Reads and writes may alternate on consecutive cycles without idle slots.
- R3: A read issued on the edge right after a write to the same address returns the newly written data.
- R4: While cenN=1, all synchronous inputs are ignored. Every register holds, including commands in flight and the output word, and dIn/bwN on frozen edges are never sampled.
- R5: The chip is selected only when ce1N=0, ce2=1 and ce2N=0. A load edge with any other combination is a deselect and writes nothing.
- R6: With advN=1, the command repeats the kind (read, write or deselect) of the last load. Its address keeps the upper bits of the loaded address, and its two low bits step through a wrapping four-word burst. With LINEAR_BURST=1 (default) the low bits are base+k mod 4; otherwise they are base XOR k, for k=1,2,3,0. A continue after a deselect is a deselect.
- R7: bwN[i]=0 writes lane i, which is dIn bits [9i+8:9i]. Lanes whose bwN bit is 1 keep their contents, and bwN=4'b1111 leaves the word unchanged.
- R8: oeN=1 forces dOutValid=0 and dOut=0 at once, without a clock edge. Lowering oeN restores the registered word.
- R9: The output slot belonging to a deselect, a write or an aborted write shows dOutValid=0 and dOut=0.
- R10: A synchronous active-high rst clears all in-flight commands and the output flag and drops a write due at that edge. It does not clear stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of pipeline state |
| cenN | input | 1 | Active-low clock enable; high freezes the block |
| advN | input | 1 | Low loads a new address, high continues the burst |
| ce1N | input | 1 | Active-low chip enable |
| ce2 | input | 1 | Active-high chip enable |
| ce2N | input | 1 | Second active-low chip enable |
| weN | input | 1 | Low selects write, high selects read on a load |
| bwN | input | 4 | Active-low lane write strobes, sampled with write data |
| oeN | input | 1 | Asynchronous active-low output enable |
| addr | input | ADDR_W | Word address |
| dIn | input | 36 | Write data, sampled two enabled edges after the command |
| dOut | output | 36 | Read data, zero when not driven |
| dOutValid | output | 1 | High when dOut is driven with read data |

## Verification
The hardest case to reach from the ports is a clock-enable freeze that lands while a write is still waiting for its data. The frozen edges carry junk on dIn and bwN and an enabled write command, and none of these may be taken. The bench drives such a freeze between a write command and its data slot, then reads the word back. A second freeze sits under two reads in flight, and the bench checks that the held output word survives it. A reset pulse is placed on top of a pending read to show that the read never surfaces while the stored word does.

// File: rtl/turnless_pkg.sv
package turnless_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } opKind_t;

  // strobes from control to datapath, one set per clock
  typedef struct packed {
    logic step;    // enabled edge
    logic rdSlot;  // a read reaches its data slot at this edge
    logic wrSlot;  // a write reaches its data slot at this edge
  } pipeStb_t;
endpackage

// File: rtl/turnless_burst.sv
module turnless_burst #(
  parameter int ADDR_W       = 6,
  parameter int BURST_BITS   = 2,
  parameter bit LINEAR_BURST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              load,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] cmdAddr
);
  logic [ADDR_W-1:0]     baseQ;
  logic [BURST_BITS-1:0] cntQ;
  logic [BURST_BITS-1:0] nextCnt;
  logic [BURST_BITS-1:0] lowBits;

  assign nextCnt = cntQ + 1'b1;

  generate
    if (LINEAR_BURST) begin : g_linear
      assign lowBits = baseQ[BURST_BITS-1:0] + nextCnt;
    end else begin : g_interleave
      assign lowBits = baseQ[BURST_BITS-1:0] ^ nextCnt;
    end
  endgenerate

  assign cmdAddr = load ? extAddr : {baseQ[ADDR_W-1:BURST_BITS], lowBits};

  always_ff @(posedge clk) begin
    if (rst) begin
      baseQ <= '0;
      cntQ  <= '0;
    end else if (step) begin
      if (load) begin
        baseQ <= extAddr;
        cntQ  <= '0;
      end else begin
        cntQ <= nextCnt;
      end
    end
  end
endmodule

// File: rtl/turnless_ctrl.sv
module turnless_ctrl
  import turnless_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cenN,
  input  logic              advN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce2N,
  input  logic              weN,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              burstLoad,
  output pipeStb_t          stb,
  output logic [ADDR_W-1:0] slotAddr
);
  opKind_t lastKindQ;
  opKind_t curKind;
  logic    selected;
  logic    step;

  // two command stages between the command edge and the data edge
  logic              s1ValidQ, s1WriteQ;
  logic [ADDR_W-1:0] s1AddrQ;
  logic              s2ValidQ, s2WriteQ;
  logic [ADDR_W-1:0] s2AddrQ;

  assign step      = !cenN;
  assign burstLoad = !advN;
  assign selected  = !ce1N && ce2 && !ce2N;

  always_comb begin
    if (burstLoad) begin
      if (!selected)  curKind = OP_IDLE;
      else if (weN)   curKind = OP_RD;
      else            curKind = OP_WR;
    end else begin
      curKind = lastKindQ;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lastKindQ <= OP_IDLE;
      s1ValidQ  <= 1'b0;
      s1WriteQ  <= 1'b0;
      s1AddrQ   <= '0;
      s2ValidQ  <= 1'b0;
      s2WriteQ  <= 1'b0;
      s2AddrQ   <= '0;
    end else if (step) begin
      lastKindQ <= curKind;
      s1ValidQ  <= (curKind != OP_IDLE);
      s1WriteQ  <= (curKind == OP_WR);
      s1AddrQ   <= cmdAddr;
      s2ValidQ  <= s1ValidQ;
      s2WriteQ  <= s1WriteQ;
      s2AddrQ   <= s1AddrQ;
    end
  end

  always_comb begin
    stb.step   = step && !rst;
    stb.rdSlot = s2ValidQ && !s2WriteQ;
    stb.wrSlot = s2ValidQ && s2WriteQ;
  end

  assign slotAddr = s2AddrQ;
endmodule

// File: rtl/turnless_dpath.sv
module turnless_dpath
  import turnless_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  pipeStb_t          stb,
  input  logic [ADDR_W-1:0] slotAddr,
  input  logic [LANES-1:0]  bwN,
  input  logic [DATA_W-1:0] dIn,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // array commit: lanes picked by the strobes sampled at the data edge
  always_ff @(posedge clk) begin
    if (stb.step && stb.wrSlot) begin
      for (int l = 0; l < LANES; l++) begin
        if (!bwN[l]) mem[slotAddr][l*LANE_W +: LANE_W] <= dIn[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else if (stb.step) begin
      rdValid <= stb.rdSlot;
      rdData  <= stb.rdSlot ? mem[slotAddr] : '0;
    end
  end
endmodule

// File: rtl/turnless_sram.sv
module turnless_sram
  import turnless_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int BURST_BITS   = 2,
  parameter bit LINEAR_BURST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cenN,
  input  logic              advN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce2N,
  input  logic              weN,
  input  logic [LANES-1:0]  bwN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOutValid
);
  pipeStb_t          stb;
  logic              burstLoad;
  logic [ADDR_W-1:0] cmdAddr;
  logic [ADDR_W-1:0] slotAddr;
  logic              rdValidQ;
  logic [DATA_W-1:0] rdDataQ;

  turnless_burst #(
    .ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS), .LINEAR_BURST(LINEAR_BURST)
  ) burst_i (
    .clk(clk), .rst(rst), .step(stb.step), .load(burstLoad),
    .extAddr(addr), .cmdAddr(cmdAddr)
  );

  turnless_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst(rst), .cenN(cenN), .advN(advN),
    .ce1N(ce1N), .ce2(ce2), .ce2N(ce2N), .weN(weN),
    .cmdAddr(cmdAddr), .burstLoad(burstLoad), .stb(stb), .slotAddr(slotAddr)
  );

  turnless_dpath #(.ADDR_W(ADDR_W)) dpath_i (
    .clk(clk), .rst(rst), .stb(stb), .slotAddr(slotAddr),
    .bwN(bwN), .dIn(dIn), .rdValid(rdValidQ), .rdData(rdDataQ)
  );

  assign dOutValid = rdValidQ && !oeN;
  assign dOut      = dOutValid ? rdDataQ : '0;
endmodule

// File: rtl/turnless_sram_chk.sv
module turnless_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              cenN,
  input logic              advN,
  input logic              ce1N,
  input logic              ce2,
  input logic              ce2N,
  input logic              weN,
  input logic              rdValid,
  input logic [DATA_W-1:0] rdData
);
  logic selOk;
  assign selOk = !ce1N && ce2 && !ce2N;

  // R10
  reset_clear_chk: assert property (@(posedge clk) rst |=> !rdValid);

  // R4
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cenN |=> ($stable(rdValid) && $stable(rdData)));

  // R1
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (!cenN && !advN && selOk && weN) ##1 !cenN ##1 !cenN |=> rdValid);

  // R9
  idle_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (!cenN && !advN && (!selOk || !weN)) ##1 !cenN ##1 !cenN |=> !rdValid);
endmodule

bind turnless_sram turnless_sram_chk #(.DATA_W(turnless_pkg::DATA_W)) chk_i (
  .clk(clk), .rst(rst), .cenN(cenN), .advN(advN), .ce1N(ce1N), .ce2(ce2),
  .ce2N(ce2N), .weN(weN), .rdValid(rdValidQ), .rdData(rdDataQ)
);

// File: tb/turnless_sram_tb_top.sv
`timescale 1ns/100ps
module turnless_sram_tb_top;
  localparam int AW = 6;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cenN = 1'b0, advN = 1'b0, ce1N = 1'b1, ce2 = 1'b1, ce2N = 1'b0;
  logic          weN = 1'b1, oeN = 1'b0;
  logic [3:0]    bwN = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dIn = '0;
  logic [DW-1:0] dOut;
  logic          dOutValid;

  always #2.5 clk = ~clk;

  turnless_sram dut_i (
    .clk(clk), .rst(rst), .cenN(cenN), .advN(advN), .ce1N(ce1N), .ce2(ce2),
    .ce2N(ce2N), .weN(weN), .bwN(bwN), .oeN(oeN), .addr(addr), .dIn(dIn),
    .dOut(dOut), .dOutValid(dOutValid)
  );

  typedef struct { bit v; logic [DW-1:0] d; string tag; } exp_t;
  exp_t q[$];

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference state
  logic [DW-1:0] mMem [1<<AW];
  bit            p1v, p1w, p2v, p2w;
  bit [AW-1:0]   p1a, p2a;
  bit [3:0]      p1bw, p2bw;
  bit [DW-1:0]   p1d, p2d;
  string         p1tag = "R9", p2tag = "R9";
  int            lastKind = 0;
  bit [AW-1:0]   bBase = '0;
  bit [1:0]      bCnt = '0;
  bit            lastV = 1'b0;
  bit [DW-1:0]   lastD = '0;

  task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // one command cycle; write data and strobes of the command two slots back are driven automatically
  task automatic tick(input bit cen_, input bit adv_, input int selc, input bit we_,
                      input bit [AW-1:0] a, input bit [3:0] bw_, input bit [DW-1:0] d_, input string tag);
    exp_t e;
    int kind;
    bit [AW-1:0] ca;
    @(negedge clk);
    cenN = cen_; advN = adv_; ce1N = (selc == 1); ce2 = (selc != 2); ce2N = (selc == 3);
    weN = we_; addr = a;
    if (p2v && p2w) begin bwN = p2bw; dIn = p2d; end
    else begin bwN = 4'($urandom); dIn = {4'($urandom), 32'($urandom)}; end
    @(posedge clk);
    if (!cen_) begin
      e.v = p2v && !p2w;
      e.d = e.v ? mMem[p2a] : '0;
      e.tag = p2tag;
      q.push_back(e);
      if (p2v && p2w)
        for (int l = 0; l < 4; l++) if (!p2bw[l]) mMem[p2a][l*9 +: 9] = p2d[l*9 +: 9];
      if (!adv_) begin
        kind = (selc != 0) ? 0 : (we_ ? 1 : 2);
        lastKind = kind; bBase = a; bCnt = 0; ca = a;
      end else begin
        kind = lastKind; bCnt = bCnt + 2'd1;
        ca = {bBase[AW-1:2], bBase[1:0] + bCnt};
      end
      p2v = p1v; p2w = p1w; p2a = p1a; p2bw = p1bw; p2d = p1d; p2tag = p1tag;
      p1v = (kind != 0); p1w = (kind == 2); p1a = ca; p1bw = bw_; p1d = d_; p1tag = tag;
    end
  endtask

  task automatic rd(input bit [AW-1:0] a, input string tag);
    tick(1'b0, 1'b0, 0, 1'b1, a, 4'hF, '0, tag);
  endtask
  task automatic wr(input bit [AW-1:0] a, input bit [3:0] bw_, input bit [DW-1:0] d_, input string tag);
    tick(1'b0, 1'b0, 0, 1'b0, a, bw_, d_, tag);
  endtask
  task automatic ds(input int selc, input string tag);
    tick(1'b0, 1'b0, selc, 1'b0, 6'd5, 4'h0, 36'hBAD_BAD_BAD, tag);
  endtask
  task automatic cont(input bit [DW-1:0] d_, input string tag);
    tick(1'b0, 1'b1, 0, 1'b1, '0, 4'h0, d_, tag);
  endtask

  // frozen edges with a junk write command and junk data on the bus
  task automatic freeze(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cenN = 1'b1; advN = 1'b0; ce1N = 1'b0; ce2 = 1'b1; ce2N = 1'b0; weN = 1'b0;
      addr = AW'($urandom); bwN = 4'h0; dIn = {4'($urandom), 32'($urandom)};
      @(posedge clk); #1;
      chk(dOutValid == lastV && dOut == lastD, "R4", {3'b0, dOutValid, dOut}, {3'b0, lastV, lastD});
    end
  endtask

  // monitor: compares the slot expected for each enabled edge
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(dOutValid == e.v && dOut == e.d, e.tag, {3'b0, dOutValid, dOut}, {3'b0, e.v, e.d});
      lastV = e.v; lastD = e.d;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk(dOutValid == 1'b0 && dOut == '0, "R10", {3'b0, dOutValid, dOut}, 40'h0);
    @(negedge clk); rst = 1'b0;

    // R1 R2 R3: back-to-back mixed traffic
    wr(0, 4'h0, 36'h1_1111_1111, "R2");
    rd(0, "R3");
    wr(1, 4'h0, 36'h2_2222_2222, "R2");
    rd(1, "R3");
    rd(0, "R1");
    wr(2, 4'h0, 36'h3_3333_3333, "R2");
    wr(3, 4'h0, 36'h4_4444_4444, "R2");
    rd(2, "R1");
    rd(3, "R1");

    // R7: lane strobes and abort
    wr(5, 4'h0, 36'hA_BCDE_F012, "R7");
    wr(5, 4'b1010, 36'h5_5555_5555, "R7");
    wr(5, 4'hF, 36'hF_FFFF_FFFF, "R7");
    rd(5, "R7");

    // R5: three deselect flavours attempting writes
    ds(1, "R5"); ds(2, "R5"); ds(3, "R5");
    rd(5, "R5");

    // R6: burst write from 9 then burst read, wrap checked at 8
    wr(9, 4'h0, 36'h0_0000_0E00, "R6");
    cont(36'h0_0000_0E01, "R6");
    cont(36'h0_0000_0E02, "R6");
    cont(36'h0_0000_0E03, "R6");
    rd(9, "R6");
    cont('0, "R6"); cont('0, "R6"); cont('0, "R6");
    rd(8, "R6");
    ds(1, "R9");
    cont('0, "R6");

    // R4: freeze with reads in flight, then with a write awaiting data
    rd(0, "R4"); rd(1, "R4");
    freeze(3);
    ds(1, "R9"); ds(1, "R9");
    wr(7, 4'h0, 36'h7_0707_0707, "R4");
    freeze(2);
    ds(1, "R9"); ds(1, "R9");
    rd(7, "R4");
    ds(1, "R9"); ds(1, "R9");

    // R8: asynchronous output enable
    rd(3, "R8"); ds(1, "R9"); ds(1, "R9");
    #1.5; oeN = 1'b1; #0.3;
    chk(dOutValid == 1'b0 && dOut == '0, "R8", {3'b0, dOutValid, dOut}, 40'h0);
    oeN = 1'b0; #0.3;
    chk(dOutValid == 1'b1 && dOut == 36'h4_4444_4444, "R8", {3'b0, dOutValid, dOut}, {4'h1, 36'h4_4444_4444});

    // R10: reset drops a pending read but keeps the array
    wr(20, 4'h0, 36'hC_0FFE_E020, "R10");
    ds(1, "R9"); ds(1, "R9");
    rd(20, "R10");
    @(negedge clk); rst = 1'b1; cenN = 1'b0; advN = 1'b0; ce1N = 1'b1;
    @(posedge clk);
    p1v = 0; p2v = 0; p1w = 0; p2w = 0; lastKind = 0; bBase = '0; bCnt = '0; q.delete();
    #1;
    chk(dOutValid == 1'b0, "R10", {39'b0, dOutValid}, 40'h0);
    lastV = 0; lastD = '0;
    @(negedge clk); rst = 1'b0;
    ds(1, "R10"); ds(1, "R10");
    rd(20, "R10");
    ds(1, "R9"); ds(1, "R9");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule